// File: doc/BRIEF.md
# Guest Interruption Register Access Gate

This block rules on every access a guest makes, in virtual mode, to its private copies of the interruption control registers. It takes a single request per cycle. Each request carries the direction, a register index, the write data with its NaT bit, and, for a read, the destination general register. Alongside the request come the current stacked-frame size, a per-guest acceleration control word and the guest's virtual status fields (the ic bit and the current privilege level).

One cycle after the request the block reports exactly one outcome. The access either completes against a small register file held inside the block, or is handed to the hypervisor as an intercept, or raises one architectural fault with a code. Reads and writes can each be enabled for in-guest completion separately. When the matching enable is clear, the access goes to the hypervisor untouched. When it is set, a fixed ladder of guest-visible checks runs, and only an access that passes all of them reaches the registers.

The register file has eleven entries, indexed 0 to 10 in this order: psr copy, status, instruction pointer, fault address, translation info, instruction-previous address, frame marker, immediate, hash address, bundle 0, bundle 1.

Top module: `vcr_access_gate`

## Requirements
- R1: Every request with `req_valid` high yields `rsp_valid` high for exactly one cycle, on the clock edge after the one that samples the request. With no request, `rsp_valid` stays low. `rsp_kind` encodes 0 = done, 1 = intercept, 2 = fault. `rsp_fault` is 0 unless the kind is fault.
- R2: Bit 0 of `accel_ctrl` enables in-guest reads and bit 1 enables in-guest writes. When the bit for the request's direction is clear, the outcome is intercept with fault code 0, no fault check applies, and no register changes.
- R3: For an enabled access, an index of 11 or above, or a nonzero `vic`, gives fault code 1 (illegal operation). This outranks every other fault.
- R4: For an enabled read, a destination of register 0, or a destination of 32 or above whose offset from 32 is greater than or equal to `frame_size`, gives fault code 1. Destinations 1 to 31, and stacked registers inside the frame, are legal.
- R5: A nonzero `vcpl` on an enabled access that passed the R3 and R4 checks gives fault code 2 (privileged operation).
- R6: An enabled write with `req_nat` set that passed the R3 and R5 checks gives fault code 3 (NaT consumption).
- R7: An enabled write that passed R3, R5 and R6, and sets any bit under the target's reserved mask, gives fault code 4 (reserved field). The default masks by index are: 0: FFFF_E000_0000_0001, 1: FFFF_FF00_0000_0000, 2: 0000_0000_0000_000F, 3: 0, 4: FFFF_FFFF_0000_0003, 5: 0000_0000_0000_000F, 6: 7FFF_FFFF_C000_0000, 7: FFFF_FFFF_FFE0_0000, 8: 0000_0000_0000_0007, 9: 0, 10: 0.
- R8: An enabled write to index 3 that passed every earlier check gives fault code 5 (unimplemented address) unless data bits 63..48 all equal bit 47. This is the lowest-priority fault.
- R9: A done write stores its data in the indexed register. A write with any other outcome leaves every register unchanged. A done read returns the stored value on `rsp_rdata` in the cycle `rsp_valid` is high. Reset clears all registers to zero.
- R10: `rsp_rdata` is zero in every response that is not a done read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 4 | Target register index |
| req_wdata | input | 64 | Write data |
| req_nat | input | 1 | NaT bit of the write source |
| req_dst | input | 7 | Destination general register of a read |
| frame_size | input | 7 | Size of the current stacked frame |
| accel_ctrl | input | 2 | Per-guest enables: bit 0 read, bit 1 write |
| vic | input | 1 | Guest virtual interruption-collection bit |
| vcpl | input | 2 | Guest virtual current privilege level |
| rsp_valid | output | 1 | Outcome pulse |
| rsp_kind | output | 2 | Outcome kind |
| rsp_fault | output | 3 | Fault code |
| rsp_rdata | output | 64 | Read data of a done read |

## Verification
Several fault conditions often hold for the same request. A nonzero ic bit can coincide with a nonzero privilege level, a set NaT bit, reserved bits and an out-of-range fault address. The disable of a direction can also land together with all of these. The random phase draws each condition independently with a high enough rate that such pile-ups are common, and directed cases stack them on purpose. Each response is judged against a bench priority model that must pick the single highest-ranked outcome and must show that the register behind it did not change.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

   typedef enum logic [1:0] {
      KIND_DONE      = 2'd0,
      KIND_INTERCEPT = 2'd1,
      KIND_FAULT     = 2'd2
   } kind_e;

   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_ILLEGAL = 3'd1,
      FLT_PRIV    = 3'd2,
      FLT_NAT     = 3'd3,
      FLT_RSVD    = 3'd4,
      FLT_UNIMPL  = 3'd5
   } fault_e;

   localparam int DEF_NUM_CR  = 11;
   localparam int DEF_DATA_W  = 64;
   localparam int STACK_BASE  = 32;

   // reserved-bit masks for the default register set, index order
   function automatic logic [DEF_NUM_CR*DEF_DATA_W-1:0] default_rsv_masks();
      logic [DEF_DATA_W-1:0] m [DEF_NUM_CR];
      logic [DEF_NUM_CR*DEF_DATA_W-1:0] packed_m;
      m[0]  = 64'hFFFF_E000_0000_0001;
      m[1]  = 64'hFFFF_FF00_0000_0000;
      m[2]  = 64'h0000_0000_0000_000F;
      m[3]  = 64'h0000_0000_0000_0000;
      m[4]  = 64'hFFFF_FFFF_0000_0003;
      m[5]  = 64'h0000_0000_0000_000F;
      m[6]  = 64'h7FFF_FFFF_C000_0000;
      m[7]  = 64'hFFFF_FFFF_FFE0_0000;
      m[8]  = 64'h0000_0000_0000_0007;
      m[9]  = 64'h0000_0000_0000_0000;
      m[10] = 64'h0000_0000_0000_0000;
      packed_m = '0;
      for (int i = 0; i < DEF_NUM_CR; i++) begin
         packed_m[i*DEF_DATA_W +: DEF_DATA_W] = m[i];
      end
      return packed_m;
   endfunction

endpackage

// File: rtl/vcr_va_check.sv
module vcr_va_check #(
   parameter int DATA_W  = 64,
   parameter int IMPL_VA = 48
) (
   input  logic [DATA_W-1:0] addr,
   output logic              canonical
);

   generate
      if (IMPL_VA >= DATA_W) begin : g_full
         assign canonical = 1'b1;
      end else begin : g_ext
         localparam int HI_W = DATA_W - IMPL_VA;
         logic [HI_W-1:0] hi_bits;
         logic [HI_W-1:0] sign_ext;
         assign hi_bits   = addr[DATA_W-1:IMPL_VA];
         assign sign_ext  = {HI_W{addr[IMPL_VA-1]}};
         assign canonical = (hi_bits == sign_ext);
      end
   endgenerate

endmodule

// File: rtl/vcr_fault_eval.sv
module vcr_fault_eval
   import vcr_pkg::*;
#(
   parameter int NUM_CR  = 11,
   parameter int IDX_W   = 4,
   parameter int DATA_W  = 64,
   parameter int GR_W    = 7,
   parameter int IMPL_VA = 48,
   parameter int IFA_IDX = 3,
   parameter logic [NUM_CR*DATA_W-1:0] RSV_MASKS = '0
) (
   input  logic              is_write,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              nat,
   input  logic [GR_W-1:0]   dst,
   input  logic [GR_W-1:0]   sof,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              vic,
   input  logic [1:0]        vcpl,
   output kind_e             kind,
   output fault_e            fault
);

   localparam int SLOTS = 2**IDX_W;

   logic [SLOTS-1:0] rsv_hit;
   logic             idx_ok;
   logic             canon;
   logic             acc_en;
   logic             dst_bad;
   logic             out_frame;
   logic [GR_W:0]    rel_dst;
   logic             rsv_sel;
   logic             is_ifa;

   // per-register reserved-field hit, unused slots never hit
   genvar g;
   generate
      for (g = 0; g < SLOTS; g++) begin : g_rsv
         if (g < NUM_CR) begin : g_real
            assign rsv_hit[g] = |(wdata & RSV_MASKS[g*DATA_W +: DATA_W]);
         end else begin : g_pad
            assign rsv_hit[g] = 1'b0;
         end
      end
   endgenerate

   vcr_va_check #(
      .DATA_W (DATA_W),
      .IMPL_VA(IMPL_VA)
   ) u_va (
      .addr     (wdata),
      .canonical(canon)
   );

   assign idx_ok    = ({1'b0, idx} < (IDX_W+1)'(NUM_CR));
   assign is_ifa    = (idx == IDX_W'(IFA_IDX));
   assign acc_en    = is_write ? wr_en : rd_en;
   assign rel_dst   = {1'b0, dst} - (GR_W+1)'(STACK_BASE);
   assign out_frame = ({1'b0, dst} >= (GR_W+1)'(STACK_BASE)) && (rel_dst >= {1'b0, sof});
   assign dst_bad   = (dst == '0) || out_frame;
   assign rsv_sel   = rsv_hit[idx];

   always_comb begin
      kind  = KIND_DONE;
      fault = FLT_NONE;
      if (!acc_en) begin
         kind = KIND_INTERCEPT;
      end else if (!idx_ok || vic || (!is_write && dst_bad)) begin
         kind  = KIND_FAULT;
         fault = FLT_ILLEGAL;
      end else if (vcpl != 2'd0) begin
         kind  = KIND_FAULT;
         fault = FLT_PRIV;
      end else if (is_write && nat) begin
         kind  = KIND_FAULT;
         fault = FLT_NAT;
      end else if (is_write && rsv_sel) begin
         kind  = KIND_FAULT;
         fault = FLT_RSVD;
      end else if (is_write && is_ifa && !canon) begin
         kind  = KIND_FAULT;
         fault = FLT_UNIMPL;
      end
   end

endmodule

// File: rtl/vcr_regfile.sv
module vcr_regfile #(
   parameter int NUM_CR = 11,
   parameter int IDX_W  = 4,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] regs [NUM_CR];

   genvar g;
   generate
      for (g = 0; g < NUM_CR; g++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
               regs[g] <= wr_data;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CR; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_data = regs[i];
         end
      end
   end

endmodule

// File: rtl/vcr_access_gate.sv
module vcr_access_gate
   import vcr_pkg::*;
#(
   parameter int NUM_CR    = vcr_pkg::DEF_NUM_CR,
   parameter int DATA_W    = vcr_pkg::DEF_DATA_W,
   parameter int IDX_W     = $clog2(NUM_CR),
   parameter int GR_W      = 7,
   parameter int IMPL_VA   = 48,
   parameter int IFA_IDX   = 3,
   parameter int CTRL_W    = 2,
   parameter int RD_EN_BIT = 0,
   parameter int WR_EN_BIT = 1,
   parameter logic [NUM_CR*DATA_W-1:0] RSV_MASKS = vcr_pkg::default_rsv_masks()
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_nat,
   input  logic [GR_W-1:0]   req_dst,
   input  logic [GR_W-1:0]   frame_size,
   input  logic [CTRL_W-1:0] accel_ctrl,
   input  logic              vic,
   input  logic [1:0]        vcpl,
   output logic              rsp_valid,
   output logic [1:0]        rsp_kind,
   output logic [2:0]        rsp_fault,
   output logic [DATA_W-1:0] rsp_rdata
);

   // elaboration-time parameter checks
   generate
      if (NUM_CR < 1 || IDX_W < $clog2(NUM_CR)) begin : g_bad_idx
         $error("vcr_access_gate: index width too small for register count");
      end
      if (IFA_IDX >= NUM_CR) begin : g_bad_ifa
         $error("vcr_access_gate: fault-address index out of range");
      end
      if (IMPL_VA < 1 || IMPL_VA > DATA_W) begin : g_bad_va
         $error("vcr_access_gate: implemented address width out of range");
      end
      if (RD_EN_BIT >= CTRL_W || WR_EN_BIT >= CTRL_W || RD_EN_BIT == WR_EN_BIT) begin : g_bad_ctrl
         $error("vcr_access_gate: enable bit positions invalid");
      end
      if (GR_W < 6) begin : g_bad_gr
         $error("vcr_access_gate: register number too narrow for stacked base");
      end
   endgenerate

   kind_e             ev_kind;
   fault_e            ev_fault;
   logic [DATA_W-1:0] file_rd;
   logic              commit_wr;
   logic              done_rd;

   vcr_fault_eval #(
      .NUM_CR   (NUM_CR),
      .IDX_W    (IDX_W),
      .DATA_W   (DATA_W),
      .GR_W     (GR_W),
      .IMPL_VA  (IMPL_VA),
      .IFA_IDX  (IFA_IDX),
      .RSV_MASKS(RSV_MASKS)
   ) u_eval (
      .is_write(req_write),
      .idx     (req_index),
      .wdata   (req_wdata),
      .nat     (req_nat),
      .dst     (req_dst),
      .sof     (frame_size),
      .rd_en   (accel_ctrl[RD_EN_BIT]),
      .wr_en   (accel_ctrl[WR_EN_BIT]),
      .vic     (vic),
      .vcpl    (vcpl),
      .kind    (ev_kind),
      .fault   (ev_fault)
   );

   assign commit_wr = req_valid &&  req_write && (ev_kind == KIND_DONE);
   assign done_rd   = req_valid && !req_write && (ev_kind == KIND_DONE);

   vcr_regfile #(
      .NUM_CR(NUM_CR),
      .IDX_W (IDX_W),
      .DATA_W(DATA_W)
   ) u_file (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (commit_wr),
      .wr_idx (req_index),
      .wr_data(req_wdata),
      .rd_idx (req_index),
      .rd_data(file_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_kind  <= '0;
         rsp_fault <= '0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_kind  <= req_valid ? ev_kind  : KIND_DONE;
         rsp_fault <= req_valid ? ev_fault : FLT_NONE;
         rsp_rdata <= done_rd ? file_rd : '0;
      end
   end

endmodule

// File: rtl/vcr_access_gate_chk.sv
module vcr_access_gate_chk #(
   parameter int NUM_CR    = 11,
   parameter int DATA_W    = 64,
   parameter int IDX_W     = 4,
   parameter int GR_W      = 7,
   parameter int CTRL_W    = 2,
   parameter int RD_EN_BIT = 0,
   parameter int WR_EN_BIT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [IDX_W-1:0]  req_index,
   input logic              req_nat,
   input logic [GR_W-1:0]   req_dst,
   input logic [CTRL_W-1:0] accel_ctrl,
   input logic              vic,
   input logic [1:0]        vcpl,
   input logic              rsp_valid,
   input logic [1:0]        rsp_kind,
   input logic [2:0]        rsp_fault,
   input logic [DATA_W-1:0] rsp_rdata
);

   logic idx_in;
   assign idx_in = ({1'b0, req_index} < (IDX_W+1)'(NUM_CR));

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);  // R1

   AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);  // R1

   AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_kind != 2'd3));  // R1

   AST_CODE_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind != 2'd2) |-> (rsp_fault == 3'd0));  // R1

   AST_WR_OFF_INTERCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !accel_ctrl[WR_EN_BIT]) |=> (rsp_kind == 2'd1));  // R2

   AST_RD_OFF_INTERCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !accel_ctrl[RD_EN_BIT]) |=> (rsp_kind == 2'd1));  // R2

   AST_VIC_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && vic && (req_write ? accel_ctrl[WR_EN_BIT] : accel_ctrl[RD_EN_BIT]))
      |=> (rsp_kind == 2'd2 && rsp_fault == 3'd1));  // R3

   AST_READ_GR0_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && accel_ctrl[RD_EN_BIT] && req_dst == '0)
      |=> (rsp_fault == 3'd1));  // R4

   AST_CPL_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && accel_ctrl[WR_EN_BIT] && !vic && idx_in && vcpl != 2'd0)
      |=> (rsp_kind == 2'd2 && rsp_fault == 3'd2));  // R5

   AST_NAT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && accel_ctrl[WR_EN_BIT] && !vic && idx_in && vcpl == 2'd0 && req_nat)
      |=> (rsp_kind == 2'd2 && rsp_fault == 3'd3));  // R6

   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind != 2'd0) |-> (rsp_rdata == '0));  // R10

endmodule

bind vcr_access_gate vcr_access_gate_chk #(
   .NUM_CR   (NUM_CR),
   .DATA_W   (DATA_W),
   .IDX_W    (IDX_W),
   .GR_W     (GR_W),
   .CTRL_W   (CTRL_W),
   .RD_EN_BIT(RD_EN_BIT),
   .WR_EN_BIT(WR_EN_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_index (req_index),
   .req_nat   (req_nat),
   .req_dst   (req_dst),
   .accel_ctrl(accel_ctrl),
   .vic       (vic),
   .vcpl      (vcpl),
   .rsp_valid (rsp_valid),
   .rsp_kind  (rsp_kind),
   .rsp_fault (rsp_fault),
   .rsp_rdata (rsp_rdata)
);

// File: tb/sim_vcr_access_gate.sv
`timescale 1ns/1ps
module sim_vcr_access_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_index = '0;
   logic [63:0] req_wdata = '0;
   logic        req_nat = 1'b0;
   logic [6:0]  req_dst = '0;
   logic [6:0]  frame_size = '0;
   logic [1:0]  accel_ctrl = '0;
   logic        vic = 1'b0;
   logic [1:0]  vcpl = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_kind;
   logic [2:0]  rsp_fault;
   logic [63:0] rsp_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [63:0] model [11];

   always #4 clk = ~clk;

   vcr_access_gate u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_index(req_index), .req_wdata(req_wdata), .req_nat(req_nat),
      .req_dst(req_dst), .frame_size(frame_size), .accel_ctrl(accel_ctrl),
      .vic(vic), .vcpl(vcpl), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
      .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
   );

   function automatic logic [63:0] mask_of(int i);
      case (i)
         0: return 64'hFFFF_E000_0000_0001;
         1: return 64'hFFFF_FF00_0000_0000;
         2: return 64'h0000_0000_0000_000F;
         4: return 64'hFFFF_FFFF_0000_0003;
         5: return 64'h0000_0000_0000_000F;
         6: return 64'h7FFF_FFFF_C000_0000;
         7: return 64'hFFFF_FFFF_FFE0_0000;
         8: return 64'h0000_0000_0000_0007;
         default: return 64'h0;
      endcase
   endfunction

   // returns {kind[1:0], fault[2:0]}
   function automatic logic [4:0] expect_out(bit wr, int idx, logic [63:0] d, bit nat,
                                             int dst, int sof, logic [1:0] ctrl,
                                             bit v, logic [1:0] cpl);
      bit en = wr ? ctrl[1] : ctrl[0];
      bit dbad = (dst == 0) || (dst >= 32 && (dst - 32) >= sof);
      bit canon = (d[63:48] == {16{d[47]}});
      if (!en) return {2'd1, 3'd0};
      if (idx >= 11 || v || (!wr && dbad)) return {2'd2, 3'd1};
      if (cpl != 0) return {2'd2, 3'd2};
      if (wr && nat) return {2'd2, 3'd3};
      if (wr && ((d & mask_of(idx)) != 0)) return {2'd2, 3'd4};
      if (wr && idx == 3 && !canon) return {2'd2, 3'd5};
      return {2'd0, 3'd0};
   endfunction

   function automatic string tag_of(bit wr, logic [4:0] e);
      if (e[4:3] == 2'd1) return "R2";
      case (e[2:0])
         3'd1: return "R3";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return wr ? "R9" : "R9";
      endcase
   endfunction

   task automatic do_req(bit wr, int idx, logic [63:0] d, bit nat, int dst, int sof,
                         logic [1:0] ctrl, bit v, logic [1:0] cpl, string tag);
      logic [4:0] e;
      logic [63:0] exp_rd;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_index = 4'(idx); req_wdata = d;
      req_nat = nat; req_dst = 7'(dst); frame_size = 7'(sof); accel_ctrl = ctrl;
      vic = v; vcpl = cpl;
      e = expect_out(wr, idx, d, nat, dst, sof, ctrl, v, cpl);
      exp_rd = (!wr && e == 5'd0) ? model[idx] : 64'h0;
      if (tag == "") tag = tag_of(wr, e);
      @(negedge clk);
      total++;
      if (rsp_valid !== 1'b1 || rsp_kind !== e[4:3] || rsp_fault !== e[2:0] ||
          rsp_rdata !== exp_rd) begin
         bad++;
         $display("FAIL %s: valid=%0b kind=%0d fault=%0d rdata=%h expected valid=1 kind=%0d fault=%0d rdata=%h",
                  tag, rsp_valid, rsp_kind, rsp_fault, rsp_rdata, e[4:3], e[2:0], exp_rd);
      end
      if (wr && e == 5'd0) model[idx] = d;
      req_valid = 1'b0;
   endtask

   task automatic check_idle(string tag);
      @(negedge clk);
      total++;
      if (rsp_valid !== 1'b0) begin
         bad++;
         $display("FAIL %s: idle rsp_valid=%0b expected 0", tag, rsp_valid);
      end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 11; i++) model[i] = 64'h0;
      repeat (3) @(negedge clk);
      total++;
      if (rsp_valid !== 1'b0) begin
         bad++;
         $display("FAIL R1: reset rsp_valid=%0b expected 0", rsp_valid);
      end
      rst_n = 1'b1;
      // R9 reset contents are zero
      for (int i = 0; i < 11; i++) do_req(0, i, 0, 0, 5, 0, 2'b11, 0, 0, "R9");
      check_idle("R1");
      // R2 disabled directions intercept and leave state alone
      do_req(1, 2, 64'h1230, 0, 0, 0, 2'b01, 1, 3, "R2");
      do_req(0, 2, 0, 0, 0, 0, 2'b10, 1, 3, "R2");
      do_req(0, 2, 0, 0, 9, 0, 2'b01, 0, 0, "R2");
      // R3 bad index and vic outrank others
      do_req(1, 11, 64'h0, 0, 0, 0, 2'b11, 0, 0, "R3");
      do_req(0, 15, 64'h0, 0, 9, 0, 2'b11, 0, 0, "R3");
      do_req(1, 3, 64'hFFFF_0000_0000_0001, 1, 0, 0, 2'b11, 1, 2, "R3");
      // R4 destination checks
      do_req(0, 1, 0, 0, 0, 10, 2'b11, 0, 0, "R4");
      do_req(0, 1, 0, 0, 42, 10, 2'b11, 0, 0, "R4");
      do_req(0, 1, 0, 0, 41, 10, 2'b11, 0, 0, "R4");
      do_req(0, 1, 0, 0, 31, 0, 2'b11, 0, 0, "R4");
      do_req(0, 1, 0, 0, 32, 0, 2'b11, 0, 0, "R4");
      // R5 privilege above NaT; R6 NaT above reserved
      do_req(1, 0, 64'h1, 1, 0, 0, 2'b11, 0, 3, "R5");
      do_req(0, 0, 0, 0, 5, 0, 2'b11, 0, 1, "R5");
      do_req(1, 0, 64'h1, 1, 0, 0, 2'b11, 0, 0, "R6");
      // R7 reserved field; R8 fault address form
      do_req(1, 0, 64'h1, 0, 0, 0, 2'b11, 0, 0, "R7");
      do_req(1, 6, 64'h4000_0000_0000_0000, 0, 0, 0, 2'b11, 0, 0, "R7");
      do_req(1, 3, 64'h0001_0000_0000_0000, 0, 0, 0, 2'b11, 0, 0, "R8");
      do_req(1, 3, 64'hFFFF_8000_0000_1000, 0, 0, 0, 2'b11, 0, 0, "R8");
      do_req(0, 3, 0, 0, 7, 0, 2'b11, 0, 0, "R8");
      // R9 write then read back; R10 faulted read gives zero data
      do_req(1, 10, 64'hDEAD_BEEF_0BAD_F00D, 0, 0, 0, 2'b11, 0, 0, "R9");
      do_req(0, 10, 0, 0, 3, 0, 2'b11, 0, 0, "R9");
      do_req(0, 10, 0, 0, 0, 0, 2'b11, 0, 0, "R10");
      check_idle("R1");
      // random mix
      for (int n = 0; n < 3000; n++) begin
         bit wr = $urandom_range(0, 1);
         int idx = ($urandom_range(0, 15) == 0) ? $urandom_range(11, 15) : $urandom_range(0, 10);
         logic [63:0] d = {$urandom, $urandom};
         bit nat = ($urandom_range(0, 7) == 0);
         int dst = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 127);
         int sof = $urandom_range(0, 96);
         logic [1:0] ctrl = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b11;
         bit v = ($urandom_range(0, 7) == 0);
         logic [1:0] cpl = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
         if ($urandom_range(0, 1) == 1 && idx < 11) d = d & ~mask_of(idx);
         if (idx == 3 && $urandom_range(0, 1) == 1) d = {{16{d[47]}}, d[47:0]};
         do_req(wr, idx, d, nat, dst, sof, ctrl, v, cpl, "");
      end
      // final sweep: every register matches the model
      for (int i = 0; i < 11; i++) do_req(0, i, 0, 0, 5, 0, 2'b11, 0, 0, "R9");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule